// File: doc/BRIEF.md
# System Management Interrupt Pin Handshake Controller

This block handles the processor side of a bidirectional, open-drain system management interrupt line. The chipset pulls the line low to ask for service. The block samples that level, passes it through a two-flop synchroniser when the chipset drives it asynchronously, and counts consecutive low samples until the request qualifies. It then sends a one-cycle entry request to the core and takes over the line. The block holds the line low for the whole handler. When the core reports the resume instruction, the block drives the line high for one clock and then releases it.

Only one service can be in progress at a time. Low levels that the block drives itself never start a second entry. After a service ends, the line has to be sampled high before the block accepts the next request. A trap-hit flag tells the I/O logic whether a request was sampled early enough, relative to an I/O cycle's ready signal, to trap that cycle.

Top module: `smi_pin_handshake`

## Requirements
- R1: With `asyncMode` = 0, a single clock edge that captures `pinIn` low while the block is armed is enough to recognise a request. `entryReq`, `pinOe` and `inSmm` go high after the next clock edge.
- R2: With `asyncMode` = 1, the request goes through two flip-flops and must be seen low on two consecutive edges. A low level that lasts one clock is ignored. When the line is low on two edges, the outputs rise after the third edge that follows the first low capture.
- R3: From entry until a resume strobe is taken, the block drives the line low, with `pinOe` = 1 and `pinOut` = 0, on every cycle.
- R4: A `resumeStb` pulse received during service makes the block drive the line high (`pinOe` = 1, `pinOut` = 1) for exactly one cycle. `pinOe` is 0 on the cycle after that.
- R5: After a release, no new request is accepted until the line has been sampled high at least once. A line that stays low through the release does not start another entry.
- R6: Only one service runs at a time. `entryReq` is a single-cycle pulse, and low levels on the line during service cause no further entry.
- R7: `trapHit` is high in any cycle where `ioRdy` is high and the line was sampled low in the armed state two clocks earlier.
- R8: `inSmm` is high from the cycle of `entryReq` through the one-cycle release, and low otherwise.
- R9: Reset clears all state. `pinOe`, `entryReq`, `inSmm` and `trapHit` are 0, and the block must see the line high before it accepts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | Sampled level of the interrupt line (low = request) |
| asyncMode | input | 1 | 1: chipset drives the line asynchronously; 0: synchronously |
| ioRdy | input | 1 | Ready signal of the current I/O cycle |
| resumeStb | input | 1 | Core pulse: resume instruction executed |
| pinOe | output | 1 | Output enable for the line driver |
| pinOut | output | 1 | Level driven on the line while `pinOe` is high |
| entryReq | output | 1 | One-cycle request to the core to enter the handler |
| inSmm | output | 1 | Service in progress |
| trapHit | output | 1 | The request met the trap lead time for this I/O cycle |

## Verification
The line is modelled as a wired-AND of the chipset's pull-down and the block's own driver. This lets the block's own low drive and the chipset's low level overlap the way they do on a board. Directed runs separate the two modes: a low level lasting one clock must start service in synchronous mode and must be ignored in asynchronous mode. A line held low through the release must not re-trigger the block, while a single high sample followed by low must. Random chipset pull-down runs of varying length, random resume strobes and random ready pulses are then compared cycle by cycle against a reference model built from the requirements. These runs show whether entry latency, the one-cycle release and the trap lead time line up under overlapping stimulus.

// File: rtl/smi_hs_pkg.sv
package smi_hs_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_HIGH = 2'd0,
    ST_ARMED     = 2'd1,
    ST_SERVICE   = 2'd2,
    ST_RELEASE   = 2'd3
  } hsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic armed;
  } ctlStrb_t;

endpackage

// File: rtl/smi_hs_datapath.sv
module smi_hs_datapath
  import smi_hs_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int ASYNC_MIN_LOW = 2,
  parameter int TRAP_LEAD     = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pinIn,
  input  logic     asyncMode,
  input  logic     ioRdy,
  input  ctlStrb_t ctl,
  output logic     levelHigh,
  output logic     reqSeen,
  output logic     trapHit
);

  localparam int CNT_W = $clog2(ASYNC_MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(ASYNC_MIN_LOW);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [TRAP_LEAD-1:0]   hitPipe;
  logic [CNT_W-1:0]       lowCnt;
  logic [CNT_W-1:0]       lowRun;
  logic [CNT_W-1:0]       needLow;
  logic                   sampledLvl;

  // sampling chain: stage 0 serves the synchronous path, last stage the async one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end

  assign sampledLvl = asyncMode ? syncQ[SYNC_STAGES-1] : syncQ[0];
  assign levelHigh  = sampledLvl;
  assign needLow    = asyncMode ? CNT_MAX : CNT_ONE;

  always_comb begin
    if (sampledLvl)             lowRun = '0;
    else if (lowCnt == CNT_MAX) lowRun = CNT_MAX;
    else                        lowRun = lowCnt + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowCnt <= '0;
    else       lowCnt <= lowRun;
  end

  assign reqSeen = ctl.armed && (lowRun >= needLow);

  // trap lead tracking: an armed low sample, aged TRAP_LEAD clocks
  generate
    if (TRAP_LEAD == 1) begin : g_lead1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hitPipe <= '0;
        else       hitPipe <= ctl.armed && !sampledLvl;
      end
    end else begin : g_leadN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hitPipe <= '0;
        else       hitPipe <= {hitPipe[TRAP_LEAD-2:0], ctl.armed && !sampledLvl};
      end
    end
  endgenerate

  assign trapHit = ioRdy && hitPipe[TRAP_LEAD-1];

  AST_ASYNC_NEEDS_PRIOR_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (asyncMode && reqSeen) |-> (lowCnt != '0)); // R2

  AST_SYNC_ONE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!asyncMode && ctl.armed && !syncQ[0]) |-> reqSeen); // R1

endmodule

// File: rtl/smi_hs_control.sv
module smi_hs_control
  import smi_hs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     levelHigh,
  input  logic     reqSeen,
  input  logic     resumeStb,
  output ctlStrb_t ctl,
  output logic     pinOe,
  output logic     pinOut,
  output logic     entryReq,
  output logic     inSmm
);

  hsState_t state, stateNxt;
  logic     takeReq;

  assign takeReq = (state == ST_ARMED) && reqSeen;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_WAIT_HIGH: if (levelHigh) stateNxt = ST_ARMED;
      ST_ARMED:     if (takeReq)   stateNxt = ST_SERVICE;
      ST_SERVICE:   if (resumeStb) stateNxt = ST_RELEASE;
      ST_RELEASE:                  stateNxt = ST_WAIT_HIGH;
      default:                     stateNxt = ST_WAIT_HIGH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_WAIT_HIGH;
      entryReq <= 1'b0;
    end else begin
      state    <= stateNxt;
      entryReq <= takeReq;
    end
  end

  assign ctl.armed = (state == ST_ARMED);
  assign pinOe     = (state == ST_SERVICE) || (state == ST_RELEASE);
  assign pinOut    = (state == ST_RELEASE);
  assign inSmm     = pinOe;

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe && !pinOut && !resumeStb) |=> (pinOe && !pinOut)); // R3

  AST_RESUME_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe && !pinOut && resumeStb) |=> (pinOe && pinOut)); // R4

  AST_RELEASE_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe && pinOut) |=> !pinOe); // R4

  AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    entryReq |=> !entryReq); // R6

  AST_NO_REENTRY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe && pinOut) |=> ##1 !entryReq); // R5

  AST_ENTRY_SETS_INSMM: assert property (@(posedge clk) disable iff (!rstN)
    entryReq |-> inSmm); // R8

endmodule

// File: rtl/smi_pin_handshake.sv
module smi_pin_handshake
  import smi_hs_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int ASYNC_MIN_LOW = 2,
  parameter int TRAP_LEAD     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  input  logic asyncMode,
  input  logic ioRdy,
  input  logic resumeStb,
  output logic pinOe,
  output logic pinOut,
  output logic entryReq,
  output logic inSmm,
  output logic trapHit
);

  ctlStrb_t ctl;
  logic     levelHigh;
  logic     reqSeen;

  smi_hs_datapath #(
    .SYNC_STAGES  (SYNC_STAGES),
    .ASYNC_MIN_LOW(ASYNC_MIN_LOW),
    .TRAP_LEAD    (TRAP_LEAD)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .asyncMode(asyncMode),
    .ioRdy    (ioRdy),
    .ctl      (ctl),
    .levelHigh(levelHigh),
    .reqSeen  (reqSeen),
    .trapHit  (trapHit)
  );

  smi_hs_control ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .levelHigh(levelHigh),
    .reqSeen  (reqSeen),
    .resumeStb(resumeStb),
    .ctl      (ctl),
    .pinOe    (pinOe),
    .pinOut   (pinOut),
    .entryReq (entryReq),
    .inSmm    (inSmm)
  );

endmodule

// File: tb/smi_pin_handshake_tb.sv
module smi_pin_handshake_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extLow = 1'b0;
  logic asyncMode = 1'b0;
  logic ioRdy = 1'b0;
  logic resumeStb = 1'b0;
  logic pinIn, pinOe, pinOut, entryReq, inSmm, trapHit;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  // open-drain line: low if the chipset or the block pulls it low
  assign pinIn = extLow ? 1'b0 : (pinOe ? pinOut : 1'b1);

  smi_pin_handshake dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .asyncMode(asyncMode),
    .ioRdy(ioRdy), .resumeStb(resumeStb), .pinOe(pinOe), .pinOut(pinOut),
    .entryReq(entryReq), .inSmm(inSmm), .trapHit(trapHit)
  );

  // reference model built from the requirements
  logic mS1, mS2, mHp0, mHp1, mEntry;
  int   mCnt, mSt; // 0 wait-high, 1 armed, 2 service, 3 release

  function automatic int runOf(logic lvl, int cnt);
    if (lvl) return 0;
    return (cnt >= 2) ? 2 : cnt + 1;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 = 1'b1; mS2 = 1'b1; mHp0 = 1'b0; mHp1 = 1'b0; mEntry = 1'b0;
      mCnt = 0; mSt = 0;
    end else begin
      logic lvl; int run; bit rec;
      lvl = asyncMode ? mS2 : mS1;
      run = runOf(lvl, mCnt);
      rec = (mSt == 1) && (run >= (asyncMode ? 2 : 1));
      mHp1 = mHp0;
      mHp0 = (mSt == 1) && !lvl;
      mS2 = mS1;
      mS1 = pinIn;
      mCnt = run;
      mEntry = rec;
      case (mSt)
        0: if (lvl) mSt = 1;
        1: if (rec) mSt = 2;
        2: if (resumeStb) mSt = 3;
        default: mSt = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model, away from the edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R3 pinOe", pinOe, mSt >= 2);
      chk("R4 pinOut", pinOe & pinOut, mSt == 3);
      chk(asyncMode ? "R2 entryReq" : "R1 entryReq", entryReq, mEntry);
      chk("R8 inSmm", inSmm, mSt >= 2);
      chk("R7 trapHit", trapHit, ioRdy && mHp1);
    end
  end

  task automatic drv();
    @(posedge clk); #2;
  endtask

  task automatic doReset(input logic mode);
    rstN = 1'b0; extLow = 1'b0; resumeStb = 1'b0; ioRdy = 1'b0; asyncMode = mode;
    repeat (2) @(posedge clk);
    #2 rstN = 1'b1;
  endtask

  task automatic randPhase(input logic mode, input int n);
    int runLeft = 0;
    doReset(mode);
    for (int i = 0; i < n; i++) begin
      drv();
      if (runLeft > 0) begin
        runLeft--; extLow = 1'b1;
      end else begin
        extLow = ($urandom % 5 == 0);
        if (extLow) runLeft = $urandom % 3;
      end
      resumeStb = inSmm && ($urandom % 6 == 0);
      ioRdy = ($urandom % 3 == 0);
    end
    drv(); extLow = 1'b0; resumeStb = 1'b0; ioRdy = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset state
    doReset(1'b0);
    @(negedge clk);
    chk("R9 pinOe", pinOe, 1'b0);
    chk("R9 inSmm", inSmm, 1'b0);
    chk("R9 entryReq", entryReq, 1'b0);
    chk("R9 trapHit", trapHit, 1'b0);

    // R1: one-clock low in synchronous mode is taken
    repeat (3) drv();
    extLow = 1'b1;
    drv(); extLow = 1'b0;
    @(negedge clk); chk("R1 early", entryReq, 1'b0);
    @(negedge clk);
    chk("R1 entryReq", entryReq, 1'b1);
    chk("R3 drive low", pinOe && !pinOut, 1'b1);
    chk("R8 inSmm", inSmm, 1'b1);

    // R6: chipset low during service starts nothing
    drv(); extLow = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R6 no entry", entryReq, 1'b0);
      chk("R3 hold low", pinOe && !pinOut, 1'b1);
    end

    // R4: resume gives a one-clock high drive, line kept low by chipset
    drv(); resumeStb = 1'b1;
    drv(); resumeStb = 1'b0;
    @(negedge clk); chk("R4 release high", pinOe && pinOut, 1'b1);
    @(negedge clk); chk("R4 released", pinOe, 1'b0);
    chk("R8 inSmm end", inSmm, 1'b0);

    // R5: line still low after release -> no new entry
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R5 no rearm", inSmm, 1'b0);
      chk("R5 no entry", entryReq, 1'b0);
    end
    drv(); extLow = 1'b0;
    drv(); extLow = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 rearmed entry", entryReq, 1'b1);
    drv(); extLow = 1'b0; resumeStb = 1'b1;
    drv(); resumeStb = 1'b0;
    repeat (3) drv();

    // R2: asynchronous mode
    doReset(1'b1);
    repeat (4) drv();
    extLow = 1'b1;
    drv(); extLow = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R2 one-clock ignored", inSmm, 1'b0);
    end
    drv(); extLow = 1'b1;
    drv();
    drv(); extLow = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 not yet", entryReq, 1'b0);
    @(negedge clk);
    chk("R2 entryReq", entryReq, 1'b1);
    drv(); resumeStb = 1'b1;
    drv(); resumeStb = 1'b0;
    repeat (3) drv();

    // random traffic in both modes, compared against the model
    randPhase(1'b0, 3000);
    randPhase(1'b1, 3000);
    randPhase(1'b0, 2000);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule